// File: doc/BRIEF.md
# Sixteen-Bit Up/Down Reload Timer with Capture

The block is a 16-bit timer/counter with a 16-bit companion register that serves either as a reload value or as a capture latch. It counts either a fixed prescaled tick of the system clock or falling edges seen on an external count pin. A second external pin is the trigger: its falling edge can latch the current count or force a reload, and in up/down mode its level sets the count direction. A clock-out mode divides the system clock and toggles an output pin on every wrap.

Software programs an 8-bit control register, a 2-bit mode register, the count and the reload value through write strobes, and reads all of them back on output ports. Two sticky flags, one for counter wrap and one for trigger or wrap-toggle events, raise the interrupt request until software clears them.

Top module: `t16_reload_capture_timer`

## Requirements
- R1: With run (control bit 2) set and source select (control bit 1) clear, the count advances by one every 12 system clock cycles. The first step lands on the 12th rising edge after the write that sets run. With run clear the count holds.
- R2: With source select set, the count advances once for each falling edge of the count pin. The pin passes through two synchroniser flops, and a falling edge is a 1 in one synchronised sample followed by 0 in the next.
- R3: In reload mode (control bit 0 clear) with down-enable (mode bit 0) clear, a step taken at FFFFh loads the reload value and sets the overflow flag (control bit 7).
- R4: In reload mode with external enable (control bit 3) set and down-enable clear, a falling trigger edge copies the reload value into the count and sets the external flag (control bit 6).
- R5: In capture mode (control bit 0 set) with external enable set, a falling trigger edge copies the current count into the reload/capture register and sets the external flag. The count keeps running.
- R6: In capture mode a step at FFFFh wraps the count to 0000h and sets the overflow flag. The capture register is left unchanged.
- R7: In reload mode with down-enable set, the synchronised trigger level sets the direction: 1 counts up, 0 counts down. Going up, a step at FFFFh loads the reload value. Going down, a step taken while the count equals the reload value loads FFFFh. Each such wrap sets the overflow flag and inverts the external flag.
- R8: In up/down mode a falling trigger edge neither changes the count nor sets the external flag, even with external enable set.
- R9: With output-enable (mode bit 1) set, source select clear and reload mode, the count advances every 2 clock cycles. Each wrap from FFFFh reloads the count and inverts `clk_out`. With output-enable clear, `clk_out` is 0.
- R10: `irq` is high whenever either flag is set. A control write loads all eight bits, flags included, so writing 0 to a flag clears it.
- R11: If a capture and a wrap from FFFFh fall in the same cycle, the capture register receives FFFFh, the count becomes 0000h, and both flags set.
- R12: After reset the count, reload value, control and mode registers are zero, and `clk_out` and `irq` are 0.
- R13: Control bits 5 and 4 are stored and read back but have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_pin | input | 1 | External count pin |
| trig_pin | input | 1 | External trigger / direction pin |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode register write data (bit1 output-enable, bit0 down-enable) |
| rld_we | input | 1 | Reload/capture register write strobe |
| rld_wdata | input | 16 | Reload/capture write data |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 16 | Count write data |
| count | output | 16 | Current count |
| reload | output | 16 | Reload/capture register |
| ctrl | output | 8 | Control register including flags |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External flag |
| clk_out | output | 1 | Clock-out pin |
| irq | output | 1 | Interrupt request |

## Verification
In capture mode, a trigger capture and a counter wrap can land in the same cycle. Both must then act on the count value from before the edge. The bench provokes this by loading FFFFh and dropping the count pin and the trigger pin at the same instant. Both pass through matching synchronisers, so the two edges reach the core together. The bench then expects FFFFh in the capture register, 0000h in the count, and both flags set.

// File: rtl/t16_pkg.sv
package t16_pkg;
    // control register bit positions
    localparam int CB_OVF = 7;
    localparam int CB_EXT = 6;
    localparam int CB_RXC = 5;
    localparam int CB_TXC = 4;
    localparam int CB_XEN = 3;
    localparam int CB_RUN = 2;
    localparam int CB_SEL = 1;
    localparam int CB_CAP = 0;
    // mode register bit positions
    localparam int MB_OE   = 1;
    localparam int MB_DCEN = 0;
    // external pin indices
    localparam int PIN_CNT  = 0;
    localparam int PIN_TRIG = 1;
    localparam int NPIN     = 2;
endpackage

// File: rtl/t16_pin_sync.sv
module t16_pin_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] level
);
    logic [N-1:0] chain_q [STAGES];
    logic [N-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = pin;
        for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= chain_d[s];
        end
    end

    assign level = chain_q[STAGES-1];
endmodule

// File: rtl/t16_prescale.sv
module t16_prescale #(
    parameter int DIV_SLOW = 12,
    parameter int DIV_FAST = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fast,
    output logic tick
);
    localparam int PW = $clog2(DIV_SLOW + 1);
    localparam logic [PW-1:0] LIM_SLOW = PW'(DIV_SLOW - 1);
    localparam logic [PW-1:0] LIM_FAST = PW'(DIV_FAST - 1);

    logic [PW-1:0] pre_q, pre_d;
    logic [PW-1:0] lim;

    always_comb begin
        lim  = fast ? LIM_FAST : LIM_SLOW;
        tick = en && (pre_q >= lim);
        if (!en)       pre_d = '0;
        else if (tick) pre_d = '0;
        else           pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R1: ticks are at least two cycles apart
    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/t16_count_core.sv
module t16_count_core
    import t16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_lvl,
    input  logic            pre_tick,
    input  logic            ctrl_we,
    input  logic [7:0]      ctrl_wdata,
    input  logic            mode_we,
    input  logic [1:0]      mode_wdata,
    input  logic            rld_we,
    input  logic [W-1:0]    rld_wdata,
    input  logic            cnt_we,
    input  logic [W-1:0]    cnt_wdata,
    output logic            pre_en,
    output logic            pre_fast,
    output logic [W-1:0]    count,
    output logic [W-1:0]    reload,
    output logic [7:0]      ctrl,
    output logic            clk_out,
    output logic            irq
);
    localparam logic [W-1:0] ALL1 = '1;

    typedef struct packed {
        logic [W-1:0]    cnt;
        logic [W-1:0]    rld;
        logic [7:0]      ctl;
        logic [1:0]      mode;
        logic            tgl;
        logic [NPIN-1:0] prev;
    } state_t;

    state_t s_q, s_d;

    logic [NPIN-1:0] fall;
    logic run, csel, cap, xen, oe, dcen;
    logic clkout_mode, updown, go_up, tick, trig_evt, at_top, at_floor;

    always_comb begin
        fall        = s_q.prev & ~pin_lvl;
        run         = s_q.ctl[CB_RUN];
        csel        = s_q.ctl[CB_SEL];
        cap         = s_q.ctl[CB_CAP];
        xen         = s_q.ctl[CB_XEN];
        oe          = s_q.mode[MB_OE];
        dcen        = s_q.mode[MB_DCEN];
        clkout_mode = oe & ~csel & ~cap;
        updown      = dcen & ~cap & ~clkout_mode;
        go_up       = ~updown | pin_lvl[PIN_TRIG];
        pre_en      = run & ~csel;
        pre_fast    = clkout_mode;
        tick        = run & (csel ? fall[PIN_CNT] : pre_tick);
        trig_evt    = fall[PIN_TRIG] & xen & ~updown;
        at_top      = (s_q.cnt == ALL1);
        at_floor    = (s_q.cnt == s_q.rld);

        s_d      = s_q;
        s_d.prev = pin_lvl;
        if (ctrl_we) s_d.ctl  = ctrl_wdata;
        if (mode_we) s_d.mode = mode_wdata;
        if (rld_we)  s_d.rld  = rld_wdata;
        if (cnt_we)  s_d.cnt  = cnt_wdata;

        if (tick && !cnt_we) begin
            if (cap) begin
                s_d.cnt = s_q.cnt + 1'b1;
                if (at_top) s_d.ctl[CB_OVF] = 1'b1;
            end else if (go_up) begin
                if (at_top) begin
                    s_d.cnt = s_q.rld;
                    s_d.ctl[CB_OVF] = 1'b1;
                    if (updown)      s_d.ctl[CB_EXT] = ~s_d.ctl[CB_EXT];
                    if (clkout_mode) s_d.tgl = ~s_q.tgl;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end else begin
                if (at_floor) begin
                    s_d.cnt = ALL1;
                    s_d.ctl[CB_OVF] = 1'b1;
                    s_d.ctl[CB_EXT] = ~s_d.ctl[CB_EXT];
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
        end

        if (trig_evt) begin
            s_d.ctl[CB_EXT] = 1'b1;
            if (cap) begin
                if (!rld_we) s_d.rld = s_q.cnt;
            end else begin
                if (!cnt_we) s_d.cnt = s_q.rld;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count   = s_q.cnt;
    assign reload  = s_q.rld;
    assign ctrl    = s_q.ctl;
    assign clk_out = oe & s_q.tgl;
    assign irq     = s_q.ctl[CB_OVF] | s_q.ctl[CB_EXT];

    // R1: with run clear and no writes or trigger reload, the count holds
    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_we && !trig_evt) |=> (count == $past(count)));

    // R2: a synchronised falling edge lasts a single cycle
    a_r2_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall[PIN_CNT] |=> !fall[PIN_CNT]);

    // R3: an upward wrap in reload mode lands on the reload value
    a_r3_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_we && !trig_evt && !cap && go_up && at_top)
            |=> (count == $past(reload)));

    // R6: capture mode leaves the capture register alone without a trigger
    a_r6_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !rld_we && !trig_evt) |=> (reload == $past(reload)));

    // R7: every up/down wrap inverts the external flag
    a_r7_ext_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (updown && tick && !cnt_we && !ctrl_we &&
         ((go_up && at_top) || (!go_up && at_floor)))
            |=> (ctrl[CB_EXT] != $past(ctrl[CB_EXT])));

    // R9: the clock-out toggle moves only after a clock-out wrap
    a_r9_tgl_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.tgl) |-> $past(tick && clkout_mode && at_top && !cnt_we));
endmodule

// File: rtl/t16_reload_capture_timer.sv
module t16_reload_capture_timer
    import t16_pkg::*;
#(
    parameter int W           = 16,
    parameter int DIV_SLOW    = 12,
    parameter int DIV_FAST    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_pin,
    input  logic         trig_pin,
    input  logic         ctrl_we,
    input  logic [7:0]   ctrl_wdata,
    input  logic         mode_we,
    input  logic [1:0]   mode_wdata,
    input  logic         rld_we,
    input  logic [W-1:0] rld_wdata,
    input  logic         cnt_we,
    input  logic [W-1:0] cnt_wdata,
    output logic [W-1:0] count,
    output logic [W-1:0] reload,
    output logic [7:0]   ctrl,
    output logic         ovf_flag,
    output logic         ext_flag,
    output logic         clk_out,
    output logic         irq
);
    logic [NPIN-1:0] pins_raw, pins_lvl;
    logic pre_en, pre_fast, pre_tick;

    assign pins_raw[PIN_CNT]  = cnt_pin;
    assign pins_raw[PIN_TRIG] = trig_pin;

    t16_pin_sync #(.N(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pins_raw),
        .level (pins_lvl)
    );

    t16_prescale #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (pre_en),
        .fast  (pre_fast),
        .tick  (pre_tick)
    );

    t16_count_core #(.W(W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_lvl    (pins_lvl),
        .pre_tick   (pre_tick),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .rld_we     (rld_we),
        .rld_wdata  (rld_wdata),
        .cnt_we     (cnt_we),
        .cnt_wdata  (cnt_wdata),
        .pre_en     (pre_en),
        .pre_fast   (pre_fast),
        .count      (count),
        .reload     (reload),
        .ctrl       (ctrl),
        .clk_out    (clk_out),
        .irq        (irq)
    );

    assign ovf_flag = ctrl[CB_OVF];
    assign ext_flag = ctrl[CB_EXT];
endmodule

// File: tb/sim_t16_reload_capture_timer.sv
module sim_t16_reload_capture_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_pin = 1'b0, trig_pin = 1'b0;
    logic        ctrl_we = 1'b0, mode_we = 1'b0, rld_we = 1'b0, cnt_we = 1'b0;
    logic [7:0]  ctrl_wd = '0;
    logic [1:0]  mode_wd = '0;
    logic [15:0] rld_wd = '0, cnt_wd = '0;
    logic [15:0] count, reload;
    logic [7:0]  ctrl;
    logic        ovf_flag, ext_flag, clk_out, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam int S_CNT = 0, S_RLD = 1, S_OVF = 2, S_EXT = 3,
                   S_IRQ = 4, S_CKO = 5, S_CTL = 6;

    typedef struct {
        int          sel;
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t exp_q[$];

    always #2 clk = ~clk;

    t16_reload_capture_timer u0 (
        .clk(clk), .rst_n(rst_n), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wd), .mode_we(mode_we),
        .mode_wdata(mode_wd), .rld_we(rld_we), .rld_wdata(rld_wd),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wd), .count(count), .reload(reload),
        .ctrl(ctrl), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
        .clk_out(clk_out), .irq(irq)
    );

    function automatic logic [15:0] observe(input int sel);
        case (sel)
            S_CNT:   return count;
            S_RLD:   return reload;
            S_OVF:   return {15'd0, ovf_flag};
            S_EXT:   return {15'd0, ext_flag};
            S_IRQ:   return {15'd0, irq};
            S_CKO:   return {15'd0, clk_out};
            default: return {8'd0, ctrl};
        endcase
    endfunction

    // monitor: pops expectations and compares at the falling edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            item_t it;
            logic [15:0] got;
            it  = exp_q.pop_front();
            got = observe(it.sel);
            checks++;
            if (got !== it.exp) begin
                fails++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
            end
        end
    end

    task automatic expect_v(input int sel, input logic [15:0] e, input string r);
        exp_q.push_back('{sel, e, r});
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wd = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wr_mode(input logic [1:0] v);
        @(negedge clk); mode_we = 1'b1; mode_wd = v;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic [15:0] v);
        @(negedge clk); cnt_we = 1'b1; cnt_wd = v;
        @(negedge clk); cnt_we = 1'b0;
    endtask

    task automatic wr_rld(input logic [15:0] v);
        @(negedge clk); rld_we = 1'b1; rld_wd = v;
        @(negedge clk); rld_we = 1'b0;
    endtask

    task automatic pulse_cnt();
        @(negedge clk); cnt_pin = 1'b1;
        repeat (4) @(negedge clk);
        cnt_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic fall_trig();
        @(negedge clk); trig_pin = 1'b1;
        repeat (4) @(negedge clk);
        trig_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic fall_both();
        @(negedge clk); trig_pin = 1'b1; cnt_pin = 1'b1;
        repeat (4) @(negedge clk);
        trig_pin = 1'b0; cnt_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(1);
        // R12: reset state
        expect_v(S_CNT, 16'h0000, "R12");
        expect_v(S_RLD, 16'h0000, "R12");
        expect_v(S_CTL, 16'h0000, "R12");
        expect_v(S_IRQ, 16'h0000, "R12");
        expect_v(S_CKO, 16'h0000, "R9 R12");

        // R1: prescaled tick, one step per 12 cycles
        wr_ctrl(8'h04);
        step(120);
        expect_v(S_CNT, 16'd10, "R1");
        wr_ctrl(8'h00);
        step(30);
        expect_v(S_CNT, 16'd10, "R1 run clear holds");

        // R13: bits 5 and 4 stored, no counting effect
        wr_ctrl(8'h30);
        step(30);
        expect_v(S_CTL, 16'h0030, "R13");
        expect_v(S_CNT, 16'd10, "R13");

        // R2 and R3: counter mode, upward wrap reloads
        wr_ctrl(8'h00);
        wr_cnt(16'hFFFE);
        wr_rld(16'h1234);
        wr_ctrl(8'h06);
        pulse_cnt(); step(1);
        expect_v(S_CNT, 16'hFFFF, "R2");
        expect_v(S_OVF, 16'h0000, "R3");
        pulse_cnt(); step(1);
        expect_v(S_CNT, 16'h1234, "R3");
        expect_v(S_OVF, 16'h0001, "R3");
        expect_v(S_IRQ, 16'h0001, "R10");

        // R10: software clear
        wr_ctrl(8'h06); step(1);
        expect_v(S_OVF, 16'h0000, "R10");
        expect_v(S_IRQ, 16'h0000, "R10");

        // R4: trigger reload
        wr_ctrl(8'h0E);
        wr_cnt(16'h0050);
        fall_trig(); step(1);
        expect_v(S_CNT, 16'h1234, "R4");
        expect_v(S_EXT, 16'h0001, "R4");
        expect_v(S_IRQ, 16'h0001, "R10");

        // R5: capture, count keeps running
        wr_ctrl(8'h0F);
        wr_cnt(16'h0077);
        fall_trig(); step(1);
        expect_v(S_RLD, 16'h0077, "R5");
        expect_v(S_CNT, 16'h0077, "R5");
        expect_v(S_EXT, 16'h0001, "R5");
        pulse_cnt(); step(1);
        expect_v(S_CNT, 16'h0078, "R5");

        // R6: capture-mode overflow, no reload
        wr_ctrl(8'h0F);
        wr_cnt(16'hFFFF);
        pulse_cnt(); step(1);
        expect_v(S_CNT, 16'h0000, "R6");
        expect_v(S_OVF, 16'h0001, "R6");
        expect_v(S_RLD, 16'h0077, "R6");

        // R11: capture and wrap in the same cycle
        wr_ctrl(8'h0F);
        wr_cnt(16'hFFFF);
        fall_both(); step(1);
        expect_v(S_RLD, 16'hFFFF, "R11");
        expect_v(S_CNT, 16'h0000, "R11");
        expect_v(S_OVF, 16'h0001, "R11");
        expect_v(S_EXT, 16'h0001, "R11");

        // R7: up/down, trigger level 0 counts down
        wr_ctrl(8'h06);
        wr_mode(2'b01);
        wr_rld(16'h0010);
        wr_cnt(16'h0012);
        pulse_cnt(); pulse_cnt(); step(1);
        expect_v(S_CNT, 16'h0010, "R7");
        expect_v(S_OVF, 16'h0000, "R7");
        pulse_cnt(); step(1);
        expect_v(S_CNT, 16'hFFFF, "R7");
        expect_v(S_OVF, 16'h0001, "R7");
        expect_v(S_EXT, 16'h0001, "R7");
        @(negedge clk); trig_pin = 1'b1;
        repeat (4) @(negedge clk);
        pulse_cnt(); step(1);
        expect_v(S_CNT, 16'h0010, "R7");
        expect_v(S_EXT, 16'h0000, "R7");

        // R8: trigger ignored in up/down mode
        wr_ctrl(8'h0E);
        @(negedge clk); trig_pin = 1'b0;
        repeat (4) @(negedge clk);
        step(1);
        expect_v(S_CNT, 16'h0010, "R8");
        expect_v(S_EXT, 16'h0000, "R8");

        // R9: clock-out, step every 2 cycles, toggle per wrap
        wr_ctrl(8'h00);
        wr_mode(2'b10);
        wr_cnt(16'hFFFD);
        wr_rld(16'hFFFD);
        wr_ctrl(8'h04);
        step(6);
        expect_v(S_CNT, 16'hFFFD, "R9");
        expect_v(S_CKO, 16'h0001, "R9");
        step(6);
        expect_v(S_CKO, 16'h0000, "R9");
        expect_v(S_CNT, 16'hFFFD, "R9");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule